// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Controller

This block gathers the interrupt requests of a small 8-bit processor and hands the core one prioritised request at a time. There are three sources. Two are external, level-sensitive request lines that the requesting device raises and later drops itself. The third is a sticky request from an on-chip timer. The timer request is set by a one-clock hit pulse and stays set until software writes to the status register. Each source can be blocked by a mask bit. Software reaches the mask and the status word through a 2-bit register offset bus with an 8-bit data path.

The core supplies two signals: its interrupt-disable flag and a strobe that marks each instruction boundary. At a boundary the block decides whether to take a request. If it takes one, it raises a one-clock `take_irq` pulse together with a source code. A request that has just become eligible is held back for one boundary, so that the instruction already in the pipeline finishes before the request is taken. A request that is eligible at a boundary while the disable flag is set stays pending.

Top module: `irq3_ctrl`

## Requirements
- R1: Reading offset 3 returns the status word. Bit 2 is the timer request, bit 1 is external line 1 and bit 0 is external line 2; bits 7..3 read zero. The external bits follow the input levels after SYNC_STAGES clocks.
- R2: Reading offset 2 returns the mask in bits 2..0 with zeros above. Offsets 0 and 1 read as zero. `rd_data` is registered and shows the register selected by `reg_addr` one clock earlier.
- R3: Writing offset 2 loads the mask from `wr_data[2:0]`; the upper data bits are ignored. A mask bit at 1 blocks the source at the same bit position as in the status word. The new mask is used at the next boundary evaluation.
- R4: A `timer_hit` pulse sets the timer request, and a write of any value to offset 3 clears it. The write leaves the external bits unchanged. When a hit and a clearing write fall in the same clock, the request ends up set.
- R5: When several unmasked requests are active, the timer is chosen first, then external line 1, then external line 2. `take_src` codes these as 0, 1 and 2.
- R6: A request that becomes eligible while nothing was eligible is not taken at the first boundary that follows. It is taken at the second boundary if it is still eligible and interrupts are enabled.
- R7: No request is taken at a boundary while `cpu_irq_dis` is 1. The request stays pending and is taken at the first later boundary with the flag clear.
- R8: If every eligible request drops before it is taken, the pending state is cancelled. A new request after that waits a full extra boundary again.
- R9: `take_irq` is a one-clock pulse, registered in the clock that follows the boundary strobe. Two consecutive clocks never both carry `take_irq`. After a take, the next take again waits one boundary.
- R10: After reset the mask and the timer request are clear, no request is pending, `take_irq` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset for reads and writes |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| ext_irq1 | input | 1 | External request line 1, level-sensitive, active high |
| ext_irq2 | input | 1 | External request line 2, level-sensitive, active high |
| timer_hit | input | 1 | One-clock pulse that sets the timer request |
| cpu_irq_dis | input | 1 | Interrupt-disable flag of the core |
| insn_end | input | 1 | Instruction-boundary strobe |
| take_irq | output | 1 | One-clock pulse: a request is taken |
| take_src | output | 2 | Source of the taken request: 0 timer, 1 line 1, 2 line 2 |

## Verification
A wrong pending flag shows up as a take that arrives one boundary early, one boundary late or never. The bench therefore drives the boundary strobe one pulse at a time and compares every `take_irq` cycle, expected or not, in the clock right after each strobe. A corrupted mask or timer latch becomes visible at the read port one clock after the offset is presented. It also surfaces as a wrong `take_src` at the next take.

// File: rtl/irq3_pkg.sv
package irq3_pkg;
  localparam int NSRC   = 3;
  localparam int ADDR_W = 2;

  // register offsets; the status bit order is decoded by software
  localparam logic [ADDR_W-1:0] OFS_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd3;

  // status / mask bit positions
  localparam int BIT_EXT2  = 0;
  localparam int BIT_EXT1  = 1;
  localparam int BIT_TIMER = 2;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'd0,
    SRC_EXT1  = 2'd1,
    SRC_EXT2  = 2'd2
  } src_e;
endpackage

// File: rtl/irq3_src_in.sv
module irq3_src_in #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext1_i,
  input  logic       ext2_i,
  input  logic       timer_hit_i,
  input  logic       timer_ack_i,
  output logic [2:0] status_o
);
  import irq3_pkg::*;

  logic [1:0] ext_raw;
  logic [1:0] ext_sync;
  logic       timer_q;

  assign ext_raw = {ext1_i, ext2_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    if (SYNC_STAGES <= 1) begin : g_one
      logic st_q;
      always_ff @(posedge clk) begin
        if (rst) st_q <= 1'b0;
        else     st_q <= ext_raw[g];
      end
      assign ext_sync[g] = st_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] st_q;
      always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= {st_q[SYNC_STAGES-2:0], ext_raw[g]};
      end
      assign ext_sync[g] = st_q[SYNC_STAGES-1];
    end
  end

  // sticky timer request: a hit wins over an acknowledge in the same clock
  always_ff @(posedge clk) begin
    if (rst)              timer_q <= 1'b0;
    else if (timer_hit_i) timer_q <= 1'b1;
    else if (timer_ack_i) timer_q <= 1'b0;
  end

  assign status_o[BIT_TIMER] = timer_q;
  assign status_o[BIT_EXT1]  = ext_sync[1];
  assign status_o[BIT_EXT2]  = ext_sync[0];

  AST_TIMER_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (timer_ack_i && !timer_hit_i) |=> !timer_q); // R4
  AST_TIMER_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
    timer_hit_i |=> timer_q); // R4
endmodule

// File: rtl/irq3_regs.sv
module irq3_regs #(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [irq3_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [2:0]                 status_i,
  output logic [2:0]                 mask_o,
  output logic                       ack_o,
  output logic [DATA_W-1:0]          rd_data
);
  import irq3_pkg::*;

  logic [2:0]        mask_q;
  logic [DATA_W-1:0] rd_next;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:3];
  assign ack_o  = wr_en && (addr == OFS_STAT);
  assign mask_o = mask_q;

  always_ff @(posedge clk) begin
    if (rst)                           mask_q <= '0;
    else if (wr_en && addr == OFS_MASK) mask_q <= wr_data[2:0];
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      OFS_MASK: rd_next[2:0] = mask_q;
      OFS_STAT: rd_next[2:0] = status_i;
      default:  rd_next      = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_MASK) |=> (mask_q == $past(wr_data[2:0]))); // R3
  AST_LOW_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr[1] == 1'b0) |=> (rd_data == '0)); // R2
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == OFS_STAT) |=> (rd_data[DATA_W-1:3] == '0)); // R1
endmodule

// File: rtl/irq3_pick.sv
module irq3_pick #(
  parameter int NSRC  = 3,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]  req_i,   // index 0 is the highest priority
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq3_ctrl.sv
module irq3_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ext_irq1,
  input  logic              ext_irq2,
  input  logic              timer_hit,
  input  logic              cpu_irq_dis,
  input  logic              insn_end,
  output logic              take_irq,
  output logic [1:0]        take_src
);
  import irq3_pkg::*;

  logic [2:0]      status_w;
  logic [2:0]      mask_w;
  logic            ack_w;
  logic [2:0]      elig_w;
  logic [NSRC-1:0] prio_w;
  logic            any_w;
  logic [1:0]      pick_w;
  logic            armed_q;
  logic            take_now;

  irq3_src_in #(.SYNC_STAGES(SYNC_STAGES)) i_src (
    .clk(clk), .rst(rst), .ext1_i(ext_irq1), .ext2_i(ext_irq2),
    .timer_hit_i(timer_hit), .timer_ack_i(ack_w), .status_o(status_w)
  );

  irq3_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(reg_addr), .wr_data(wr_data),
    .status_i(status_w), .mask_o(mask_w), .ack_o(ack_w), .rd_data(rd_data)
  );

  assign elig_w = status_w & ~mask_w;

  // reorder status positions into priority order: index 0 = timer
  for (genvar g = 0; g < NSRC; g++) begin : g_prio
    assign prio_w[g] = elig_w[NSRC-1-g];
  end

  irq3_pick #(.NSRC(NSRC)) i_pick (
    .req_i(prio_w), .any_o(any_w), .idx_o(pick_w)
  );

  // armed: something was eligible at an earlier boundary and stayed so
  assign take_now = insn_end && armed_q && any_w && !cpu_irq_dis;

  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b0;
    else if (!any_w)   armed_q <= 1'b0;
    else if (insn_end) armed_q <= !take_now;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq <= 1'b0;
      take_src <= SRC_TIMER;
    end else begin
      take_irq <= take_now;
      if (take_now) take_src <= pick_w;
    end
  end

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(insn_end)); // R9
  AST_TAKE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq); // R9
  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> !$past(cpu_irq_dis)); // R7
  AST_TIMER_FIRST: assert property (@(posedge clk) disable iff (rst)
    (take_irq && $past(elig_w[BIT_TIMER])) |-> (take_src == SRC_TIMER)); // R5
  AST_SRC_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (take_src != 2'd3)); // R5
  AST_TAKEN_WAS_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> ($past(elig_w) != 3'b000)); // R3
endmodule

// File: tb/test_irq3_ctrl.sv
`timescale 1ns/1ps
module test_irq3_ctrl;
  localparam int DATA_W = 8;
  localparam int SYNC   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        reg_addr = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic              ext_irq1 = 1'b0, ext_irq2 = 1'b0, timer_hit = 1'b0;
  logic              cpu_irq_dis = 1'b0, insn_end = 1'b0;
  logic              take_irq;
  logic [1:0]        take_src;

  int n_run = 0, n_fail = 0;
  logic [2:0] exp_q[$];   // {take, src}
  string      req_q[$];

  always #2 clk = ~clk;

  irq3_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC)) i_irq3_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_irq1(ext_irq1), .ext_irq2(ext_irq2),
    .timer_hit(timer_hit), .cpu_irq_dis(cpu_irq_dis), .insn_end(insn_end),
    .take_irq(take_irq), .take_src(take_src)
  );

  // monitor: every clock after a strobe is compared; any other take is a failure
  initial begin
    forever begin
      logic was_bnd;
      @(posedge clk);
      was_bnd = insn_end && !rst;
      #1;
      if (was_bnd) begin
        logic [2:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        n_run++;
        if (take_irq !== e[2] || (e[2] && take_src !== e[1:0])) begin
          n_fail++;
          $display("FAIL %s: take=%0d src=%0d expected take=%0d src=%0d",
                   r, take_irq, take_src, e[2], e[1:0]);
        end
      end else if (!rst && take_irq) begin
        n_run++; n_fail++;
        $display("FAIL R9: take=1 src=%0d expected take=0 outside boundary", take_src);
      end
    end
  end

  task automatic settle(int n = 6);
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary(logic exp_take, logic [1:0] exp_src, string r);
    @(negedge clk);
    insn_end = 1'b1;
    exp_q.push_back({exp_take, exp_src});
    req_q.push_back(r);
    @(negedge clk);
    insn_end = 1'b0;
    settle(2);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string r);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    n_run++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: rd[%0d]=%h expected %h", r, a, rd_data, exp);
    end
  endtask

  task automatic hit;
    @(negedge clk); timer_hit = 1'b1;
    @(negedge clk); timer_hit = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rd(2'd3, 8'h00, "R10");
    rd(2'd2, 8'h00, "R10");
    boundary(1'b0, 2'd0, "R10");
    boundary(1'b0, 2'd0, "R10");
    // R2, R3 mask access
    wr(2'd2, 8'h05); rd(2'd2, 8'h05, "R3");
    wr(2'd2, 8'hFA); rd(2'd2, 8'h02, "R3");
    rd(2'd0, 8'h00, "R2");
    rd(2'd1, 8'h00, "R2");
    wr(2'd2, 8'h00);
    // R1 status bit order
    ext_irq2 = 1'b1; settle(); rd(2'd3, 8'h01, "R1");
    ext_irq1 = 1'b1; settle(); rd(2'd3, 8'h03, "R1");
    hit();           settle(); rd(2'd3, 8'h07, "R1");
    // R6 deferral, R5 priority
    boundary(1'b0, 2'd0, "R6");
    boundary(1'b1, 2'd0, "R5");
    wr(2'd3, 8'h5A); rd(2'd3, 8'h03, "R4");
    boundary(1'b0, 2'd0, "R9");
    boundary(1'b1, 2'd1, "R5");
    wr(2'd2, 8'h02);
    boundary(1'b0, 2'd0, "R9");
    boundary(1'b1, 2'd2, "R3");
    wr(2'd2, 8'h07);
    boundary(1'b0, 2'd0, "R3");
    boundary(1'b0, 2'd0, "R3");
    // R7 disable flag holds the request
    wr(2'd2, 8'h00);
    cpu_irq_dis = 1'b1;
    boundary(1'b0, 2'd0, "R7");
    boundary(1'b0, 2'd0, "R7");
    boundary(1'b0, 2'd0, "R7");
    cpu_irq_dis = 1'b0;
    boundary(1'b1, 2'd1, "R7");
    // R8 cancel on drop
    ext_irq1 = 1'b0; ext_irq2 = 1'b0; settle();
    boundary(1'b0, 2'd0, "R8");
    ext_irq1 = 1'b1; settle();
    boundary(1'b0, 2'd0, "R6");
    ext_irq1 = 1'b0; settle();
    ext_irq1 = 1'b1; settle();
    boundary(1'b0, 2'd0, "R8");
    boundary(1'b1, 2'd1, "R8");
    // R4 hit and acknowledge in the same clock
    ext_irq1 = 1'b0; settle();
    @(negedge clk);
    timer_hit = 1'b1; wr_en = 1'b1; reg_addr = 2'd3; wr_data = 8'h00;
    @(negedge clk);
    timer_hit = 1'b0; wr_en = 1'b0;
    rd(2'd3, 8'h04, "R4");
    wr(2'd3, 8'hFF); rd(2'd3, 8'h00, "R4");
    settle(4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule